// File: doc/BRIEF.md
# Process-Tagged Translation Buffer with Access Checking

This block caches recent virtual-to-physical page translations in eight fully associative entries and checks each access against the permissions stored with the page. A request presents a virtual address, an access kind and the current process ID. One cycle later the block returns one of two results. The first is a physical address built from the cached frame number and the untouched page offset. The second is a fault code telling software whether the page was unknown, not resident, or not permitted.

Every entry is tagged with a process ID, so translations belonging to different processes can sit side by side and no flush is needed on a context switch. When a lookup faults, software walks its page tables elsewhere, installs the entry through the refill port and re-issues the access. Each entry keeps an accessed flag and a dirty flag. The accessed flag drives victim selection on refill. The dirty flag is reported with each successful translation. A flush command empties the buffer.

Top module: `tlb_prot`

## Requirements
- R1: After reset every entry is invalid, rsp_valid, rsp_hit, rsp_dirty are 0, rsp_fault is 2'b00 and rsp_paddr is 0; the first lookup after reset faults with the miss code.
- R2: A request taken while lk_valid is high is answered on the outputs exactly one clock later with rsp_valid high; a cycle without a request gives rsp_valid low on the next cycle.
- R3: A successful lookup sets rsp_hit and drives rsp_paddr with the stored frame number above the unchanged 12-bit page offset of the request.
- R4: A hit needs both the 20-bit page number and the process ID to match one entry; otherwise the result is rsp_fault = 2'b01 (miss).
- R5: The presence code is 2'b01 resident, 2'b10 on disk, 2'b00 unallocated (2'b11 counts as not resident); a matching entry that is not resident gives rsp_fault = 2'b11, and this takes priority over a permission failure.
- R6: Permissions are stored as {exec, write, read} in bits 2..0; access kind 2'b00 is read, 2'b01 write, 2'b10 execute, 2'b11 is never permitted. A resident match without the needed permission gives rsp_fault = 2'b10.
- R7: rsp_dirty shows, on a hit, the entry's dirty flag before that access; a permitted write hit sets the flag, a refused write does not, and a refill clears it.
- R8: A refill whose page number and process ID equal those of a valid entry overwrites that entry in place; otherwise it installs a new entry, and re-issuing the faulted access then hits.
- R9: A refill without an existing match takes the lowest-index invalid entry. If there is none, it takes the lowest-index entry whose accessed flag is clear. If every flag is set, it clears them all and takes entry 0. A successful hit sets the flag, and the refilled entry starts with it clear.
- R10: A flush invalidates every entry for lookups from the next cycle on, and a refill in the same cycle as a flush is dropped.
- R11: Whenever rsp_hit is low, rsp_paddr is 0 and rsp_dirty is 0; whenever rsp_valid is low, rsp_fault is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address of the request |
| lk_acc | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| lk_pid | input | 8 | Process ID of the request |
| fill_en | input | 1 | Install an entry |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_pid | input | 8 | Process ID to install |
| fill_pfn | input | 20 | Physical frame number to install |
| fill_loc | input | 2 | Presence code to install |
| fill_perm | input | 3 | Permissions {exec, write, read} to install |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_paddr | output | 32 | Physical address on a hit, else 0 |
| rsp_fault | output | 2 | 00 none, 01 miss, 10 protection, 11 not present |
| rsp_dirty | output | 1 | Dirty flag of the hit entry before this access |

## Verification
A corrupted tag, process ID or presence code appears on the very next response as a wrong fault code or a translation that should not exist. A wrong frame shows at once in rsp_paddr. Bad usage flags stay hidden until later. A dirty flag that is wrong shows only on the next hit to that page. An accessed flag that is wrong shows only when a refill evicts the wrong entry, so the replacement sequence is checked by probing which page went missing after each refill.

// File: rtl/tlb_prot.sv
module tlb_prot #(
  parameter int ENTRIES   = 8,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PID_W     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  input  logic [VA_W-1:0]        lk_vaddr,
  input  logic [1:0]             lk_acc,
  input  logic [PID_W-1:0]       lk_pid,
  input  logic                   fill_en,
  input  logic [VA_W-PAGE_BITS-1:0] fill_vpn,
  input  logic [PID_W-1:0]       fill_pid,
  input  logic [PA_W-PAGE_BITS-1:0] fill_pfn,
  input  logic [1:0]             fill_loc,
  input  logic [2:0]             fill_perm,
  input  logic                   flush,
  output logic                   rsp_valid,
  output logic                   rsp_hit,
  output logic [PA_W-1:0]        rsp_paddr,
  output logic [1:0]             rsp_fault,
  output logic                   rsp_dirty
);
  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PFN_W = PA_W - PAGE_BITS;
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [1:0] LOC_MEM = 2'b01;
  localparam logic [1:0] F_NONE = 2'b00, F_MISS = 2'b01, F_PROT = 2'b10, F_ABSENT = 2'b11;

  logic [ENTRIES-1:0] e_val, e_acc, e_dirty;
  logic [VPN_W-1:0]   e_vpn  [ENTRIES];
  logic [PID_W-1:0]   e_pid  [ENTRIES];
  logic [PFN_W-1:0]   e_pfn  [ENTRIES];
  logic [1:0]         e_loc  [ENTRIES];
  logic [2:0]         e_perm [ENTRIES];

  logic [ENTRIES-1:0] lk_match, fill_match;
  wire  [VPN_W-1:0]   lk_vpn = lk_vaddr[VA_W-1:PAGE_BITS];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g]   = e_val[g] && e_vpn[g] == lk_vpn   && e_pid[g] == lk_pid;
    assign fill_match[g] = e_val[g] && e_vpn[g] == fill_vpn && e_pid[g] == fill_pid;
  end

  logic [IDX_W-1:0] lk_sel, same_sel, free_sel, cold_sel, victim;
  logic             free_any, cold_any, age_reset;

  always_comb begin
    lk_sel = '0; same_sel = '0; free_sel = '0; cold_sel = '0;
    free_any = 1'b0; cold_any = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_match[i])   lk_sel   = IDX_W'(i);
      if (fill_match[i]) same_sel = IDX_W'(i);
      if (!e_val[i]) begin free_sel = IDX_W'(i); free_any = 1'b1; end
      if (!e_acc[i]) begin cold_sel = IDX_W'(i); cold_any = 1'b1; end
    end
  end

  assign age_reset = !(|fill_match) && !free_any && !cold_any;
  assign victim    = (|fill_match) ? same_sel :
                     free_any      ? free_sel :
                     cold_any      ? cold_sel : '0;

  logic allowed;
  always_comb begin
    case (lk_acc)
      2'b00:   allowed = e_perm[lk_sel][0];
      2'b01:   allowed = e_perm[lk_sel][1];
      2'b10:   allowed = e_perm[lk_sel][2];
      default: allowed = 1'b0;
    endcase
  end

  wire       resident = e_loc[lk_sel] == LOC_MEM;
  wire       hit_c    = lk_valid && (|lk_match) && resident && allowed;
  wire [1:0] fault_c  = !(|lk_match) ? F_MISS :
                        !resident    ? F_ABSENT :
                        !allowed     ? F_PROT : F_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_val   <= '0;
      e_acc   <= '0;
      e_dirty <= '0;
    end else begin
      if (hit_c) begin
        e_acc[lk_sel] <= 1'b1;
        if (lk_acc == 2'b01) e_dirty[lk_sel] <= 1'b1;
      end
      if (flush) begin
        e_val <= '0;
      end else if (fill_en) begin
        if (age_reset) e_acc <= '0;
        e_val[victim]   <= 1'b1;
        e_acc[victim]   <= 1'b0;
        e_dirty[victim] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush) begin
      e_vpn[victim]  <= fill_vpn;
      e_pid[victim]  <= fill_pid;
      e_pfn[victim]  <= fill_pfn;
      e_loc[victim]  <= fill_loc;
      e_perm[victim] <= fill_perm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= F_NONE;
      rsp_dirty <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= hit_c;
      rsp_paddr <= hit_c ? {e_pfn[lk_sel], lk_vaddr[PAGE_BITS-1:0]} : '0;
      rsp_fault <= lk_valid ? fault_c : F_NONE;
      rsp_dirty <= hit_c && e_dirty[lk_sel];
    end
  end
endmodule

// File: rtl/tlb_prot_chk.sv
module tlb_prot_chk #(
  parameter int PAGE_BITS = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 lk_valid,
  input logic [PAGE_BITS-1:0] lk_off,
  input logic                 flush,
  input logic                 rsp_valid,
  input logic                 rsp_hit,
  input logic [PAGE_BITS-1:0] rsp_off,
  input logic [1:0]           rsp_fault,
  input logic                 rsp_dirty
);
  // R2
  req_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid && !rsp_hit);

  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_off == $past(lk_off));

  // R11
  hit_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_fault == 2'b00 && rsp_valid);

  // R11
  idle_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> rsp_fault == 2'b00);

  // R7
  dirty_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_dirty |-> rsp_hit);

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) && lk_valid |=> rsp_fault == 2'b01);
endmodule

bind tlb_prot tlb_prot_chk #(.PAGE_BITS(PAGE_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid),
  .lk_off(lk_vaddr[PAGE_BITS-1:0]), .flush(flush),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_off(rsp_paddr[PAGE_BITS-1:0]), .rsp_fault(rsp_fault),
  .rsp_dirty(rsp_dirty)
);

// File: tb/test_tlb_prot.sv
`timescale 1ns/1ps
module test_tlb_prot;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        lk_valid = 1'b0, fill_en = 1'b0, flush = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [1:0]  lk_acc = '0, fill_loc = '0;
  logic [7:0]  lk_pid = '0, fill_pid = '0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0;
  logic [2:0]  fill_perm = '0;
  logic        rsp_valid, rsp_hit, rsp_dirty;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tlb_prot i_tlb_prot (.*);

  typedef struct packed {
    logic [31:0] va; logic [1:0] acc; logic [7:0] pid;
    logic hit; logic [1:0] flt; logic [31:0] pa; logic dirty; logic [7:0] req;
  } vec_t;

  localparam vec_t VEC [14] = '{
    '{32'h12345678, 2'b00, 8'd3, 1'b1, 2'b00, 32'hABCDE678, 1'b0, 8'd3}, // R3
    '{32'h12345ABC, 2'b01, 8'd3, 1'b1, 2'b00, 32'hABCDEABC, 1'b0, 8'd6}, // R6
    '{32'h12345000, 2'b00, 8'd3, 1'b1, 2'b00, 32'hABCDE000, 1'b1, 8'd7}, // R7
    '{32'h12345000, 2'b10, 8'd3, 1'b0, 2'b10, 32'h0,        1'b0, 8'd6}, // R6
    '{32'h12345001, 2'b00, 8'd4, 1'b1, 2'b00, 32'h55555001, 1'b0, 8'd4}, // R4
    '{32'h12345001, 2'b01, 8'd4, 1'b0, 2'b10, 32'h0,        1'b0, 8'd6}, // R6
    '{32'h12345002, 2'b00, 8'd4, 1'b1, 2'b00, 32'h55555002, 1'b0, 8'd7}, // R7
    '{32'h12345001, 2'b00, 8'd5, 1'b0, 2'b01, 32'h0,        1'b0, 8'd4}, // R4
    '{32'h00010FFC, 2'b10, 8'd3, 1'b1, 2'b00, 32'h00777FFC, 1'b0, 8'd6}, // R6
    '{32'h00010000, 2'b01, 8'd3, 1'b0, 2'b10, 32'h0,        1'b0, 8'd6}, // R6
    '{32'h00020010, 2'b00, 8'd3, 1'b0, 2'b11, 32'h0,        1'b0, 8'd5}, // R5
    '{32'h00030010, 2'b01, 8'd3, 1'b0, 2'b11, 32'h0,        1'b0, 8'd5}, // R5
    '{32'h99999000, 2'b00, 8'd3, 1'b0, 2'b01, 32'h0,        1'b0, 8'd4}, // R4
    '{32'h12345000, 2'b11, 8'd3, 1'b0, 2'b10, 32'h0,        1'b0, 8'd6}  // R6
  };

  task automatic expect_rsp(input string tag, input logic v, input logic h,
                            input logic [1:0] f, input logic [31:0] pa, input logic d);
    total++;
    if (rsp_valid !== v || rsp_hit !== h || rsp_fault !== f || rsp_paddr !== pa || rsp_dirty !== d) begin
      bad++;
      $display("FAIL %s: got v=%b h=%b f=%b pa=%h d=%b, want v=%b h=%b f=%b pa=%h d=%b",
               tag, rsp_valid, rsp_hit, rsp_fault, rsp_paddr, rsp_dirty, v, h, f, pa, d);
    end
  endtask

  task automatic lookup(input logic [31:0] va, input logic [1:0] acc, input logic [7:0] pid);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_acc = acc; lk_pid = pid;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic refill(input logic [19:0] vpn, input logic [7:0] pid, input logic [19:0] pfn,
                        input logic [1:0] loc, input logic [2:0] perm, input logic with_flush);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = vpn; fill_pid = pid; fill_pfn = pfn;
    fill_loc = loc; fill_perm = perm; flush = with_flush;
    @(negedge clk);
    fill_en = 1'b0; flush = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got hung run, want completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_rsp("R1 reset outputs", 0, 0, 2'b00, 32'h0, 0);
    rst_n = 1'b1;
    lookup(32'h00000123, 2'b00, 8'd0);
    expect_rsp("R1 empty after reset", 1, 0, 2'b01, 32'h0, 0);
    @(negedge clk);
    expect_rsp("R2 idle cycle", 0, 0, 2'b00, 32'h0, 0);

    refill(20'h12345, 8'd3, 20'hABCDE, 2'b01, 3'b011, 0);
    refill(20'h00010, 8'd3, 20'h00777, 2'b01, 3'b101, 0);
    refill(20'h12345, 8'd4, 20'h55555, 2'b01, 3'b001, 0);
    refill(20'h00020, 8'd3, 20'h11111, 2'b10, 3'b000, 0);
    refill(20'h00030, 8'd3, 20'h22222, 2'b00, 3'b111, 0);

    for (int i = 0; i < 14; i++) begin
      lookup(VEC[i].va, VEC[i].acc, VEC[i].pid);
      expect_rsp($sformatf("R%0d vector %0d", VEC[i].req, i), 1, VEC[i].hit, VEC[i].flt, VEC[i].pa, VEC[i].dirty);
    end

    // R8 miss, refill, retry
    lookup(32'h0ABCD010, 2'b01, 8'd3);
    expect_rsp("R8 before refill", 1, 0, 2'b01, 32'h0, 0);
    refill(20'h0ABCD, 8'd3, 20'h0BEEF, 2'b01, 3'b010, 0);
    lookup(32'h0ABCD010, 2'b01, 8'd3);
    expect_rsp("R8 retry hits", 1, 1, 2'b00, 32'h0BEEF010, 0);

    // R8 in-place overwrite, R7 dirty cleared by refill
    refill(20'h12345, 8'd3, 20'h0F0F0, 2'b01, 3'b011, 0);
    lookup(32'h12345004, 2'b00, 8'd3);
    expect_rsp("R8 R7 overwrite in place", 1, 1, 2'b00, 32'h0F0F0004, 0);

    // R10 flush
    do_flush();
    lookup(32'h00010000, 2'b00, 8'd3);
    expect_rsp("R10 flushed", 1, 0, 2'b01, 32'h0, 0);
    refill(20'h00444, 8'd1, 20'h00555, 2'b01, 3'b111, 1);
    lookup(32'h00444000, 2'b00, 8'd1);
    expect_rsp("R10 refill dropped under flush", 1, 0, 2'b01, 32'h0, 0);

    // R9 replacement order
    for (int i = 0; i < 8; i++) refill(20'(i), 8'd1, 20'(i + 'h100), 2'b01, 3'b111, 0);
    for (int i = 0; i < 7; i++) begin
      lookup({20'(i), 12'h000}, 2'b00, 8'd1);
      expect_rsp("R9 warm entries", 1, 1, 2'b00, {20'(i + 'h100), 12'h000}, 0);
    end
    refill(20'h00100, 8'd1, 20'h00AAA, 2'b01, 3'b111, 0);
    lookup(32'h00007000, 2'b00, 8'd1);
    expect_rsp("R9 cold entry evicted", 1, 0, 2'b01, 32'h0, 0);
    lookup(32'h00100000, 2'b00, 8'd1);
    expect_rsp("R9 new entry hits", 1, 1, 2'b00, 32'h00AAA000, 0);
    refill(20'h00200, 8'd1, 20'h00BBB, 2'b01, 3'b111, 0);
    lookup(32'h00000000, 2'b00, 8'd1);
    expect_rsp("R9 all warm takes entry 0", 1, 0, 2'b01, 32'h0, 0);
    lookup(32'h00200000, 2'b00, 8'd1);
    expect_rsp("R9 entry 0 refilled", 1, 1, 2'b00, 32'h00BBB000, 0);
    refill(20'h00300, 8'd1, 20'h00CCC, 2'b01, 3'b111, 0);
    lookup(32'h00001000, 2'b00, 8'd1);
    expect_rsp("R9 flags cleared then entry 1", 1, 0, 2'b01, 32'h0, 0);
    lookup(32'h00200000, 2'b00, 8'd1);
    expect_rsp("R9 entry 0 kept", 1, 1, 2'b00, 32'h00BBB000, 0);
    lookup(32'h00300000, 2'b00, 8'd1);
    expect_rsp("R9 entry 1 refilled", 1, 1, 2'b00, 32'h00CCC000, 0);

    @(negedge clk);
    expect_rsp("R11 idle outputs", 0, 0, 2'b00, 32'h0, 0);
    finish_run();
  end
endmodule